// File: doc/BRIEF.md
# DRAM Read/Write Return Latency Queue

This block sits between a DRAM command scheduler and the logic that collects returned data. Every column command that the scheduler issues pushes one entry into the queue. The entry carries the request tag, the request size in bytes, and a read/write flag. An entry leaves the queue in order. It may leave only after it has stayed for the channel's current latency: the CAS latency while the channel is in read mode, and the write latency while it is in write mode.

The channel direction follows the commands that are accepted. A write accepted in read mode turns the channel to write mode. A read accepted in write mode turns it back to read mode. The latency in force applies to every entry in the queue. A request that spans several bursts pushes one entry per burst. Each pop credits one beat's worth of bytes (burst length times bus width) to that tag's running total. The tag is reported as complete only on the pop that brings the total to at least the request size; that pop also clears the total so the tag can be used again. A peek output tells the consumer, before it pops, whether the pop would complete a request.

Top module: `dram_ret_lat_queue`

## Requirements
- R1: After reset the queue is empty and in read mode: `full_o`, `pop_rdy_o`, `peek_done_o`, `done_o` and `wr_mode_o` are all 0.
- R2: In read mode, an entry accepted at clock edge e first shows `pop_rdy_o`=1 after edge e+CL-1. It can therefore be popped at edge e+CL at the earliest, with CL=6 by default.
- R3: A write (`push_wr_i`=1) accepted in read mode sets `wr_mode_o`=1 from the next cycle. The residency then becomes WL, 2 by default, with the same edge counting as R2.
- R4: A read (`push_wr_i`=0) accepted in write mode clears `wr_mode_o` and restores the residency to CL. A cycle with no push leaves the mode unchanged.
- R5: Entries leave in the order they were accepted.
- R6: Capacity is CL+1 entries, and `full_o` is 1 exactly when that many are held. A push while full and not popping is refused, and no stored entry is lost.
- R7: `pop_i` has no effect while `pop_rdy_o`=0, which includes the empty state. No entry is consumed and `done_o` stays 0.
- R8: Each accepted pop adds BURST_LEN*BUS_BYTES bytes (16 by default) to the head tag's total. `done_o` pulses with `done_tag_o` = tag only when the new total is at least the entry's size. The total then returns to 0.
- R9: `peek_done_o` is 1 exactly when the head is poppable and popping it now would complete its request.
- R10: A push and a pop in the same cycle are both accepted even when the queue is full, and `full_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Column command issued; push one entry |
| push_wr_i | input | 1 | 1 = write command, 0 = read command |
| push_tag_i | input | TAG_W | Request tag |
| push_size_i | input | SIZE_W | Request size in bytes |
| full_o | output | 1 | Queue holds CL+1 entries |
| pop_i | input | 1 | Pop request from the data return side |
| pop_rdy_o | output | 1 | Head entry has met its residency |
| peek_done_o | output | 1 | Popping now would complete the head's request |
| done_o | output | 1 | Request completed on this pop |
| done_tag_o | output | TAG_W | Tag of the head entry / completed request |
| wr_mode_o | output | 1 | Channel in write mode |

## Verification
A corrupted age counter or a wrong latency selection appears at once as `pop_rdy_o` rising one or more cycles off the CL or WL count. The bench samples every cycle of the wait and catches this on the first entry. A broken pointer or count shows up as a wrong `done_tag_o` order within one drain, or as `full_o` at the wrong occupancy. A stale byte total shows up only at a later pop of the same tag, either as a missing completion or an early one. For that reason a multi-burst request is followed by reuse of the same tag.

// File: rtl/ddq_pkg.sv
package ddq_pkg;
  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } chan_mode_e;
endpackage

// File: rtl/ddq_mode_ctrl.sv
module ddq_mode_ctrl
  import ddq_pkg::*;
#(
  parameter int AGE_W = 3,
  parameter int CL    = 6,
  parameter int WL    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_en_i,
  input  logic             push_wr_i,
  output logic             wr_mode_o,
  output logic [AGE_W-1:0] lat_o
);
  chan_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RD;
    else if (push_en_i) mode_q <= push_wr_i ? MODE_WR : MODE_RD;
  end

  assign wr_mode_o = (mode_q == MODE_WR);
  assign lat_o     = wr_mode_o ? AGE_W'(WL) : AGE_W'(CL);
endmodule

// File: rtl/ddq_age_fifo.sv
module ddq_age_fifo #(
  parameter int DEPTH  = 7,
  parameter int TAG_W  = 4,
  parameter int SIZE_W = 8,
  parameter int AGE_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_en_i,
  input  logic [TAG_W-1:0]  push_tag_i,
  input  logic [SIZE_W-1:0] push_size_i,
  input  logic              pop_en_i,
  input  logic [AGE_W-1:0]  lat_i,
  output logic [TAG_W-1:0]  head_tag_o,
  output logic [SIZE_W-1:0] head_size_o,
  output logic              head_rdy_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [SIZE_W-1:0] size_q [DEPTH];
  logic [AGE_W-1:0]  age_q  [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = push_en_i && (wptr_q == PTR_W'(i));

    always_ff @(posedge clk_i) begin
      if (hit) begin
        tag_q[i]  <= push_tag_i;
        size_q[i] <= push_size_i;
      end
    end

    // age counts the push edge as 1 and saturates
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) age_q[i] <= '0;
      else if (hit) age_q[i] <= AGE_W'(1);
      else if (age_q[i] != '1) age_q[i] <= age_q[i] + AGE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_en_i) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + PTR_W'(1);
      if (pop_en_i)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + PTR_W'(1);
      case ({push_en_i, pop_en_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_tag_o  = tag_q[rptr_q];
  assign head_size_o = size_q[rptr_q];
  assign head_rdy_o  = (cnt_q != '0) && (age_q[rptr_q] >= lat_i);
  assign full_o      = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/ddq_beat_acc.sv
module ddq_beat_acc #(
  parameter int TAG_W      = 4,
  parameter int SIZE_W     = 8,
  parameter int BEAT_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_en_i,
  input  logic [TAG_W-1:0]  head_tag_i,
  input  logic [SIZE_W-1:0] head_size_i,
  output logic              last_o
);
  localparam int NTAG  = 2 ** TAG_W;
  localparam int SUM_W = SIZE_W + 1;

  logic [SIZE_W-1:0] acc_q [NTAG];
  logic [SUM_W-1:0]  sum;

  assign sum    = {1'b0, acc_q[head_tag_i]} + SUM_W'(BEAT_BYTES);
  assign last_o = (sum >= {1'b0, head_size_i});

  for (genvar g = 0; g < NTAG; g++) begin : g_tag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_q[g] <= '0;
      else if (pop_en_i && (head_tag_i == TAG_W'(g)))
        acc_q[g] <= last_o ? '0 : sum[SIZE_W-1:0];
    end
  end
endmodule

// File: rtl/dram_ret_lat_queue.sv
module dram_ret_lat_queue #(
  parameter int TAG_W     = 4,
  parameter int SIZE_W    = 8,
  parameter int CL        = 6,
  parameter int WL        = 2,
  parameter int BURST_LEN = 4,
  parameter int BUS_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              push_wr_i,
  input  logic [TAG_W-1:0]  push_tag_i,
  input  logic [SIZE_W-1:0] push_size_i,
  output logic              full_o,
  input  logic              pop_i,
  output logic              pop_rdy_o,
  output logic              peek_done_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  done_tag_o,
  output logic              wr_mode_o
);
  localparam int DEPTH      = CL + 1;
  localparam int LAT_MAX    = (CL > WL) ? CL : WL;
  localparam int AGE_W      = $clog2(LAT_MAX + 1);
  localparam int BEAT_BYTES = BURST_LEN * BUS_BYTES;

  logic             push_ok, pop_ok, head_rdy, last;
  logic [AGE_W-1:0] lat;
  logic [SIZE_W-1:0] head_size;

  assign pop_ok  = pop_i && head_rdy;
  assign push_ok = push_i && (!full_o || pop_ok);

  ddq_mode_ctrl #(.AGE_W(AGE_W), .CL(CL), .WL(WL)) u_mode (
    .clk_i, .rst_ni,
    .push_en_i (push_ok),
    .push_wr_i,
    .wr_mode_o,
    .lat_o     (lat)
  );

  ddq_age_fifo #(.DEPTH(DEPTH), .TAG_W(TAG_W), .SIZE_W(SIZE_W), .AGE_W(AGE_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_en_i   (push_ok),
    .push_tag_i,
    .push_size_i,
    .pop_en_i    (pop_ok),
    .lat_i       (lat),
    .head_tag_o  (done_tag_o),
    .head_size_o (head_size),
    .head_rdy_o  (head_rdy),
    .full_o
  );

  ddq_beat_acc #(.TAG_W(TAG_W), .SIZE_W(SIZE_W), .BEAT_BYTES(BEAT_BYTES)) u_acc (
    .clk_i, .rst_ni,
    .pop_en_i    (pop_ok),
    .head_tag_i  (done_tag_o),
    .head_size_i (head_size),
    .last_o      (last)
  );

  assign pop_rdy_o   = head_rdy;
  assign peek_done_o = head_rdy && last;
  assign done_o      = pop_ok && last;
endmodule

// File: rtl/ddq_checker.sv
module ddq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic push_i,
  input logic push_wr_i,
  input logic full_o,
  input logic pop_i,
  input logic pop_rdy_o,
  input logic peek_done_o,
  input logic done_o,
  input logic wr_mode_o
);
  logic pop_ok, push_ok;
  assign pop_ok  = pop_i && pop_rdy_o;
  assign push_ok = push_i && (!full_o || pop_ok);

  p_done_on_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pop_ok);
  p_peek_rdy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peek_done_o |-> pop_rdy_o);
  p_full_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o);
  p_wr_switch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok && push_wr_i |=> wr_mode_o);
  p_rd_switch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok && !push_wr_i |=> !wr_mode_o);
  p_mode_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> $stable(wr_mode_o));
  p_rdy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_rdy_o && !pop_i && !push_i |=> pop_rdy_o);
endmodule

bind dram_ret_lat_queue ddq_checker u_ddq_checker (
  .clk_i, .rst_ni, .push_i, .push_wr_i, .full_o, .pop_i,
  .pop_rdy_o, .peek_done_o, .done_o, .wr_mode_o
);

// File: tb/dram_ret_lat_queue_test.sv
module dram_ret_lat_queue_test;
  localparam int TAG_W = 4, SIZE_W = 8, CL = 6, WL = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic push_i = 0, push_wr_i = 0, pop_i = 0;
  logic [TAG_W-1:0] push_tag_i = '0;
  logic [SIZE_W-1:0] push_size_i = '0;
  logic full_o, pop_rdy_o, peek_done_o, done_o, wr_mode_o;
  logic [TAG_W-1:0] done_tag_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dram_ret_lat_queue uut (
    .clk_i(clk), .rst_ni, .push_i, .push_wr_i, .push_tag_i, .push_size_i,
    .full_o, .pop_i, .pop_rdy_o, .peek_done_o, .done_o, .done_tag_o, .wr_mode_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push1(input logic wr, input logic [TAG_W-1:0] tag, input logic [SIZE_W-1:0] sz);
    push_i = 1; push_wr_i = wr; push_tag_i = tag; push_size_i = sz;
    @(negedge clk);
    push_i = 0;
  endtask

  task automatic wait_rdy();
    for (int n = 0; n < 40 && !pop_rdy_o; n++) @(negedge clk);
  endtask

  task automatic pop_chk(input string req, input logic exp_done, input logic [TAG_W-1:0] exp_tag);
    chk(req, pop_rdy_o, 1);
    pop_i = 1;
    #1;
    chk(req, done_o, exp_done);
    chk(req, done_tag_o, exp_tag);
    @(negedge clk);
    pop_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 full", full_o, 0);
    chk("R1 rdy", pop_rdy_o, 0);
    chk("R1 peek", peek_done_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 mode", wr_mode_o, 0);
  endtask

  task automatic t_read_latency();
    push1(0, 4'd3, 8'd16);
    for (int i = 1; i < CL; i++) begin
      chk("R2 early", pop_rdy_o, 0);
      @(negedge clk);
    end
    chk("R2 on time", pop_rdy_o, 1);
    chk("R9 single beat", peek_done_o, 1);
    pop_chk("R8", 1, 4'd3);
    chk("R2 empty", pop_rdy_o, 0);
  endtask

  task automatic t_write_mode();
    push1(1, 4'd7, 8'd16);
    chk("R3 mode", wr_mode_o, 1);
    for (int i = 1; i < WL; i++) begin
      chk("R3 early", pop_rdy_o, 0);
      @(negedge clk);
    end
    chk("R3 on time", pop_rdy_o, 1);
    pop_chk("R3", 1, 4'd7);
    repeat (3) @(negedge clk);
    chk("R4 no push keeps mode", wr_mode_o, 1);
  endtask

  task automatic t_read_back();
    push1(0, 4'd8, 8'd16);
    chk("R4 mode", wr_mode_o, 0);
    for (int i = 1; i < CL; i++) begin
      chk("R4 early", pop_rdy_o, 0);
      @(negedge clk);
    end
    chk("R4 on time", pop_rdy_o, 1);
    pop_chk("R4", 1, 4'd8);
  endtask

  task automatic t_multi_burst();
    for (int b = 0; b < 3; b++) push1(0, 4'd5, 8'd48);
    wait_rdy();
    chk("R9 beat1", peek_done_o, 0);
    pop_chk("R8 beat1", 0, 4'd5);
    wait_rdy();
    chk("R9 beat2", peek_done_o, 0);
    pop_chk("R8 beat2", 0, 4'd5);
    wait_rdy();
    chk("R9 beat3", peek_done_o, 1);
    pop_chk("R8 beat3", 1, 4'd5);
    push1(0, 4'd5, 8'd16);
    chk("R9 not ready", peek_done_o, 0);
    wait_rdy();
    chk("R9 reuse", peek_done_o, 1);
    pop_chk("R8 reuse cleared", 1, 4'd5);
  endtask

  task automatic t_early_pop();
    pop_i = 1; #1;
    chk("R7 empty pop", done_o, 0);
    @(negedge clk); pop_i = 0;
    push1(0, 4'd2, 8'd16);
    pop_i = 1; #1;
    chk("R7 early pop", done_o, 0);
    @(negedge clk); pop_i = 0;
    wait_rdy();
    pop_chk("R7 entry kept", 1, 4'd2);
    chk("R7 empty after", pop_rdy_o, 0);
  endtask

  task automatic t_capacity();
    logic [TAG_W-1:0] exp_q [7] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd10};
    for (int t = 0; t < CL + 1; t++) begin
      chk("R6 not full yet", full_o, 0);
      push1(0, TAG_W'(t), 8'd16);
    end
    chk("R6 full", full_o, 1);
    push1(0, 4'd9, 8'd16);
    chk("R6 full kept", full_o, 1);
    wait_rdy();
    push_i = 1; push_wr_i = 0; push_tag_i = 4'd10; push_size_i = 8'd16;
    pop_i = 1; #1;
    chk("R10 done", done_o, 1);
    chk("R10 tag", done_tag_o, 4'd0);
    @(negedge clk);
    push_i = 0; pop_i = 0;
    chk("R10 still full", full_o, 1);
    foreach (exp_q[k]) begin
      wait_rdy();
      pop_chk("R5 order", 1, exp_q[k]);
    end
    chk("R6 drained", full_o, 0);
    repeat (CL + 2) @(negedge clk);
    chk("R6 refused push absent", pop_rdy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_read_latency();
    t_write_mode();
    t_read_back();
    t_multi_burst();
    t_early_pop();
    t_capacity();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule